// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous, idle-high serial line into parallel characters. A single-cycle enable, `os_tick`, arrives sixteen times per bit period. The receiver synchronises the line, finds a falling edge, and confirms it as a start bit with a check at mid-bit. It then samples each data bit at its centre, least significant bit first. After the data bits come an optional parity bit and one stop bit.

The character length is either the full data width or one bit less. The parity selector offers four modes, and two of them actually test the parity bit.

Each finished character is stored in a data register. Three sticky error flags report the parity, stop-bit and overrun conditions, and a status read clears them. A routing input picks where an erroneous character is signalled: either on a dedicated error interrupt or on the ordinary receive-complete interrupt. Reception runs only while both the power enable and the receive enable are high. Bit-rate generation, queueing and the register bus belong to the surrounding logic.

Top module: `serial_rx`

## Requirements
- R1: After synchronous reset, `rx_data`, all three error flags and both interrupt outputs are 0.
- R2: With `char8`=1, the DATA_W bits following the start bit are collected LSB first into `rx_data`, and a receive-complete pulse follows the stop bit.
- R3: With `char8`=0, DATA_W-1 data bits are received, and the top bit of `rx_data` reads 0.
- R4: `par_mode` selects the parity handling. In mode 0 no parity bit follows the data. Mode 2 flags `err_parity` when the data bits plus the parity bit hold an even number of ones. Mode 3 flags it when they hold an odd number.
- R5: In `par_mode`=1 a parity bit follows the data and is skipped. It never sets `err_parity` and never causes an error interrupt.
- R6: Only one stop bit is examined. If it is sampled low, `err_frame` is set.
- R7: If a character completes while the previous one has not been taken by a `data_rd` pulse, `err_overrun` is set and `rx_data` takes the new character.
- R8: A `stat_rd` pulse clears all three error flags on the next clock.
- R9: For a character with any error: when `err_route`=0, only `irq_rx_err` pulses; when `err_route`=1, only `irq_rx` pulses. An error-free character always pulses `irq_rx`. The two interrupts never pulse together.
- R10: A low level that is high again at the mid-bit check is rejected as a glitch, and nothing is received.
- R11: Reception runs only while `pwr_en` and `rx_en` are both 1. When either one drops, the receiver returns to idle and an unfinished character is discarded without an interrupt.
- R12: If the line is already low when reception is enabled, that low level is taken as a start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit |
| pwr_en | input | 1 | Power enable of the receiver |
| rx_en | input | 1 | Receive enable |
| char8 | input | 1 | 1: DATA_W data bits, 0: DATA_W-1 |
| par_mode | input | 2 | 0 none, 1 skipped, 2 odd, 3 even |
| err_route | input | 1 | 0: errors on irq_rx_err, 1: errors on irq_rx |
| rxd | input | 1 | Serial input line, idle high |
| stat_rd | input | 1 | Status read pulse, clears error flags |
| data_rd | input | 1 | Data read pulse, frees the data register |
| rx_data | output | DATA_W (8) | Last received character |
| err_parity | output | 1 | Sticky parity error flag |
| err_frame | output | 1 | Sticky stop-bit error flag |
| err_overrun | output | 1 | Sticky overrun flag |
| irq_rx | output | 1 | Receive-complete interrupt pulse |
| irq_rx_err | output | 1 | Error interrupt pulse |

## Verification
The bench uses the default width of 8, 16 ticks per bit and a two-stage synchroniser. It drives a tick every second clock, so one bit lasts 32 clocks and a whole sweep stays short. With these settings it can run every combination of parity mode, character length and error routing over eight data patterns, placing bad parity and bad stop bits at fixed points in the sweep. The same settings make it cheap to run the overrun, glitch, enable-timing and mid-character-abort cases as separate frames.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
package serial_rx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [1:0] PM_NONE = 2'd0;
  localparam logic [1:0] PM_SKIP = 2'd1;
  localparam logic [1:0] PM_ODD  = 2'd2;
  localparam logic [1:0] PM_EVEN = 2'd3;
endpackage

// File: rtl/serial_rx_sync.sv
`timescale 1ns/1ps
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/serial_rx_frame.sv
`timescale 1ns/1ps
module serial_rx_frame
  import serial_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              active,
  input  logic              line,
  input  logic              char8,
  input  logic [1:0]        pmode,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              par_err,
  output logic              frm_err
);
  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] shreg;
  logic              par_acc;
  logic [IDX_W-1:0]  idx_last;
  logic              at_end;

  assign idx_last = char8 ? IDX_FULL : IDX_SHORT;
  assign at_end   = (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      idx     <= '0;
      shreg   <= '0;
      par_acc <= 1'b0;
      par_err <= 1'b0;
      frm_err <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            cnt <= '0;
            if (!line) state <= ST_START;
          end
          ST_START: begin
            if (cnt == CNT_MID) begin
              cnt <= '0;
              if (line) begin
                state <= ST_IDLE;
              end else begin
                state   <= ST_DATA;
                idx     <= '0;
                par_acc <= 1'b0;
                par_err <= 1'b0;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (at_end) begin
              cnt     <= '0;
              shreg   <= {line, shreg[DATA_W-1:1]};
              par_acc <= par_acc ^ line;
              if (idx == idx_last) state <= (pmode == PM_NONE) ? ST_STOP : ST_PAR;
              else                 idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (at_end) begin
              cnt   <= '0;
              state <= ST_STOP;
              case (pmode)
                PM_ODD:  par_err <= ~(par_acc ^ line);
                PM_EVEN: par_err <= par_acc ^ line;
                default: par_err <= 1'b0;
              endcase
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (at_end) begin
              cnt     <= '0;
              state   <= ST_IDLE;
              frm_err <= ~line;
              done    <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  assign data = char8 ? shreg : {1'b0, shreg[DATA_W-1:1]};

  // R11: losing either enable forces the receiver back to idle
  p_idle_when_off_r11: assert property (@(posedge clk) disable iff (rst)
    !active |=> (state == ST_IDLE && !done));

  // R10: a start that is high at the mid-bit check goes back to idle
  p_glitch_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (active && tick && state == ST_START && cnt == CNT_MID && line) |=> state == ST_IDLE);
endmodule

// File: rtl/serial_rx_status.sv
`timescale 1ns/1ps
module serial_rx_status #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done,
  input  logic [DATA_W-1:0] data_in,
  input  logic              par_err_in,
  input  logic              frm_err_in,
  input  logic              char8,
  input  logic [1:0]        pmode,
  input  logic              route,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_par,
  output logic              err_frm,
  output logic              err_ovr,
  output logic              irq_done,
  output logic              irq_err
);
  logic full;
  logic ovr_new;
  logic any_err;
  logic keep;

  assign ovr_new = full && !data_rd;
  assign any_err = par_err_in || frm_err_in || ovr_new;
  assign keep    = !stat_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data  <= '0;
      full     <= 1'b0;
      err_par  <= 1'b0;
      err_frm  <= 1'b0;
      err_ovr  <= 1'b0;
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
    end else begin
      irq_done <= 1'b0;
      irq_err  <= 1'b0;
      if (data_rd) full <= 1'b0;
      if (done) begin
        rx_data  <= data_in;
        full     <= 1'b1;
        err_par  <= par_err_in || (err_par && keep);
        err_frm  <= frm_err_in || (err_frm && keep);
        err_ovr  <= ovr_new    || (err_ovr && keep);
        irq_done <= !any_err || route;
        irq_err  <= any_err && !route;
      end else if (stat_rd) begin
        err_par <= 1'b0;
        err_frm <= 1'b0;
        err_ovr <= 1'b0;
      end
    end
  end

  // R9: the two interrupt pulses never coincide
  p_irq_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(irq_done && irq_err));
  // R9: with routing to the completion interrupt, no error interrupt appears
  p_route_done_r9: assert property (@(posedge clk) disable iff (rst)
    (done && route) |=> !irq_err);
  // R5: the skipped-parity mode never reports a parity fault
  p_skip_parity_r5: assert property (@(posedge clk) disable iff (rst)
    (done && pmode == 2'd1) |-> !par_err_in);
  // R3: short characters arrive with the top bit clear
  p_short_top_r3: assert property (@(posedge clk) disable iff (rst)
    (done && !char8) |-> !data_in[DATA_W-1]);
  // R7: completion on an unread register raises the overrun flag
  p_overrun_r7: assert property (@(posedge clk) disable iff (rst)
    (done && full && !data_rd) |=> err_ovr);
  // R8: a status read with no new character leaves every flag clear
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !done) |=> (!err_par && !err_frm && !err_ovr));
endmodule

// File: rtl/serial_rx.sv
`timescale 1ns/1ps
module serial_rx #(
  parameter int DATA_W      = 8,
  parameter int OVS         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic              pwr_en,
  input  logic              rx_en,
  input  logic              char8,
  input  logic [1:0]        par_mode,
  input  logic              err_route,
  input  logic              rxd,
  input  logic              stat_rd,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              err_parity,
  output logic              err_frame,
  output logic              err_overrun,
  output logic              irq_rx,
  output logic              irq_rx_err
);
  logic              line_s;
  logic              active;
  logic              f_done;
  logic [DATA_W-1:0] f_data;
  logic              f_par;
  logic              f_frm;

  assign active = pwr_en && rx_en;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .q   (line_s)
  );

  serial_rx_frame #(.DATA_W(DATA_W), .OVS(OVS)) u_frame (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .active  (active),
    .line    (line_s),
    .char8   (char8),
    .pmode   (par_mode),
    .done    (f_done),
    .data    (f_data),
    .par_err (f_par),
    .frm_err (f_frm)
  );

  serial_rx_status #(.DATA_W(DATA_W)) u_status (
    .clk        (clk),
    .rst        (rst),
    .done       (f_done),
    .data_in    (f_data),
    .par_err_in (f_par),
    .frm_err_in (f_frm),
    .char8      (char8),
    .pmode      (par_mode),
    .route      (err_route),
    .stat_rd    (stat_rd),
    .data_rd    (data_rd),
    .rx_data    (rx_data),
    .err_par    (err_parity),
    .err_frm    (err_frame),
    .err_ovr    (err_overrun),
    .irq_done   (irq_rx),
    .irq_err    (irq_rx_err)
  );
endmodule

// File: tb/tb_serial_rx.sv
`timescale 1ns/1ps
module tb_serial_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       os_tick = 1'b0;
  logic       pwr_en = 1'b0;
  logic       rx_en = 1'b0;
  logic       char8 = 1'b1;
  logic [1:0] par_mode = 2'd0;
  logic       err_route = 1'b0;
  logic       rxd = 1'b1;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] rx_data;
  logic       err_parity, err_frame, err_overrun, irq_rx, irq_rx_err;

  int n_checks = 0;
  int n_fail = 0;
  int n_done = 0;
  int n_err = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serial_rx dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .pwr_en(pwr_en), .rx_en(rx_en),
    .char8(char8), .par_mode(par_mode), .err_route(err_route), .rxd(rxd),
    .stat_rd(stat_rd), .data_rd(data_rd), .rx_data(rx_data),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun),
    .irq_rx(irq_rx), .irq_rx_err(irq_rx_err)
  );

  // one tick every second clock
  always @(negedge clk) os_tick <= ~os_tick;

  always @(negedge clk) begin
    if (irq_rx)     n_done = n_done + 1;
    if (irq_rx_err) n_err  = n_err + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic pulse_reads();
    @(negedge clk);
    stat_rd = 1'b1;
    data_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    data_rd = 1'b0;
    @(negedge clk);
  endtask

  // en_at > 0: enable reception that many ticks into the start bit
  task automatic send_frame(input logic [7:0] d, input bit bad_par, input bit bad_stop,
                            input int en_at);
    int nb;
    logic [7:0] dm;
    logic p;
    nb = char8 ? 8 : 7;
    dm = char8 ? d : {1'b0, d[6:0]};
    rxd = 1'b0;
    if (en_at > 0) begin
      wait_ticks(en_at);
      rx_en = 1'b1;
      wait_ticks(16 - en_at);
    end else begin
      wait_ticks(16);
    end
    for (int i = 0; i < nb; i++) begin
      rxd = dm[i];
      wait_ticks(16);
    end
    if (par_mode != 2'd0) begin
      case (par_mode)
        2'd2:    p = ~(^dm);
        2'd3:    p = ^dm;
        default: p = ^dm;
      endcase
      rxd = p ^ bad_par;
      wait_ticks(16);
    end
    if (bad_stop) begin
      rxd = 1'b0;
      wait_ticks(12);
      rxd = 1'b1;
      wait_ticks(4);
    end else begin
      rxd = 1'b1;
      wait_ticks(16);
    end
    wait_ticks(4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [7:0] exp_d;
    bit bp, bs, ep, anyerr;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rx_data", rx_data, 0);
    check("R1 flags", {err_parity, err_frame, err_overrun}, 0);
    check("R1 irqs", {irq_rx, irq_rx_err}, 0);

    pwr_en = 1'b1;
    rx_en = 1'b1;
    wait_ticks(4);

    // Sweep: R2 R3 R4 R5 R6 R8 R9
    for (int m = 0; m < 4; m++) begin
      for (int c = 0; c < 2; c++) begin
        for (int k = 0; k < 8; k++) begin
          par_mode = 2'(m);
          char8 = c[0];
          err_route = k[0];
          d = 8'((k * 37 + 5 + m * 11) & 255);
          bp = (k == 3);
          bs = (k == 5);
          n_done = 0;
          n_err = 0;
          send_frame(d, bp, bs, 0);
          exp_d = char8 ? d : {1'b0, d[6:0]};
          ep = bp && (m >= 2);
          anyerr = ep || bs;
          check(char8 ? "R2 data" : "R3 data", rx_data, exp_d);
          check(m == 1 ? "R5 parity" : "R4 parity", err_parity, ep);
          check("R6 frame", err_frame, bs);
          check("R9 irq_rx", n_done, (!anyerr || err_route) ? 1 : 0);
          check("R9 irq_rx_err", n_err, (anyerr && !err_route) ? 1 : 0);
          pulse_reads();
          check("R8 cleared", {err_parity, err_frame, err_overrun}, 0);
        end
      end
    end

    // R7 overrun, routed both ways
    par_mode = 2'd0;
    char8 = 1'b1;
    for (int r = 0; r < 2; r++) begin
      err_route = r[0];
      send_frame(8'h3C, 0, 0, 0);
      n_done = 0;
      n_err = 0;
      send_frame(8'hA5, 0, 0, 0);
      check("R7 overrun", err_overrun, 1);
      check("R7 data", rx_data, 8'hA5);
      check("R9 ovr irq_rx", n_done, r);
      check("R9 ovr irq_rx_err", n_err, 1 - r);
      pulse_reads();
      check("R8 ovr cleared", err_overrun, 0);
    end
    err_route = 1'b0;

    // R10 glitch
    n_done = 0;
    n_err = 0;
    rxd = 1'b0;
    wait_ticks(3);
    rxd = 1'b1;
    wait_ticks(24);
    check("R10 glitch irqs", n_done + n_err, 0);
    send_frame(8'h96, 0, 0, 0);
    check("R10 after glitch", rx_data, 8'h96);
    pulse_reads();

    // R11 receive enable off
    n_done = 0;
    n_err = 0;
    rx_en = 1'b0;
    send_frame(8'h11, 0, 0, 0);
    check("R11 rx_en off", n_done + n_err, 0);
    // R11 power off
    rx_en = 1'b1;
    pwr_en = 1'b0;
    send_frame(8'h22, 0, 0, 0);
    check("R11 pwr off", n_done + n_err, 0);
    check("R11 data kept", rx_data, 8'h96);
    pwr_en = 1'b1;
    wait_ticks(4);
    // R11 abort mid character
    rxd = 1'b0;
    wait_ticks(16 + 16 * 4);
    rx_en = 1'b0;
    rxd = 1'b1;
    wait_ticks(16 * 6);
    rx_en = 1'b1;
    wait_ticks(4);
    check("R11 abort irqs", n_done + n_err, 0);
    send_frame(8'h5A, 0, 0, 0);
    check("R11 resume", rx_data, 8'h5A);
    check("R11 resume irq", n_done, 1);
    pulse_reads();

    // R12 line low at enable
    rx_en = 1'b0;
    wait_ticks(4);
    n_done = 0;
    n_err = 0;
    send_frame(8'hC3, 0, 0, 4);
    check("R12 data", rx_data, 8'hC3);
    check("R12 irq", n_done, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end
endmodule